// File: doc/BRIEF.md
# Byte-Wide Strobed Bus Target with Register File

This block is the target end of a byte-wide parallel bus whose host drives everything from general-purpose pins. The host frames each byte with a strobe. An address-latch level says whether the byte is a register address or part of a value. A direction line says whether the host writes or reads. A chip-select line, active low, goes high to close a transaction. The target runs on its own system clock. It passes every bus input through two-flop synchronizers and detects strobe and chip-select rising edges in that clock domain.

A transaction has one address phase followed by two value phases, high byte first. On a write, the target collects the 16-bit word and commits it to a 256-entry by 16-bit register array when chip-select rises. On a read, it drives the high byte after the first value strobe and the low byte after the second. After each complete transaction the busy line stays high for a set number of clock cycles. While it is high the host keeps re-polling with chip-select pulses, and for a read it repeats the two value phases without sending the address again. The register array stands in for the peripherals that would sit behind the port.

The phase state machine has four states. ST_NOADDR means no address has been seen since reset. ST_WAIT_HI means an address is held and the high byte is expected next. ST_WAIT_LO means the high byte is done. ST_DONE means both bytes are done. The transitions are:
- An address strobe moves any state to ST_WAIT_HI.
- A value strobe moves ST_WAIT_HI to ST_WAIT_LO, and ST_WAIT_LO to ST_DONE.
- A value strobe in ST_DONE or ST_NOADDR leaves the state unchanged.
- A chip-select rise moves ST_WAIT_LO or ST_DONE back to ST_WAIT_HI, and commits the transaction only from ST_DONE.
- A chip-select rise leaves ST_WAIT_HI and ST_NOADDR unchanged.

Top module: `byte_bus_target`

## Requirements
- R1: After reset, bus_busy_o is 0, bus_data_oe_o is 0, bus_data_o is 8'h00, and every register reads 16'h0000.
- R2: A strobe rising edge with bus_ale_i high takes bus_data_i as the register address and restarts the byte count. The next value phase is the high byte again, even if a value phase came before the address.
- R3: With bus_wr_i high (1 = write), the two value phases form the word, first byte in bits 15:8 and second byte in bits 7:0. The word is written to the addressed register when chip-select rises.
- R4: With bus_wr_i low (0 = read), bus_data_o carries bits 15:8 of the addressed register after the first value strobe and bits 7:0 after the second.
- R5: A chip-select rise that comes after only one value phase writes nothing and leaves bus_busy_o low.
- R6: A chip-select rise that completes a transaction with both value phases holds bus_busy_o high for BUSY_CYCLES clock cycles, after which it returns low (0 = done, 1 = retry).
- R7: A chip-select low pulse and rise with no strobe in between is a status re-poll. It changes no register and does not restart the busy time.
- R8: After a read completes, two new value phases with no address phase read the same register again, high byte first.
- R9: bus_data_oe_o is high only while chip-select is low, bus_wr_i is low, bus_ale_i is low and an address has been received since reset.
- R10: Value strobes after the second one in a transaction are ignored, so the committed word holds the first two value bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_strobe_i | input | 1 | Byte strobe; the rising edge marks a phase |
| bus_sel_n_i | input | 1 | Chip-select, active low; the rising edge completes or re-polls |
| bus_ale_i | input | 1 | 1 = address phase, 0 = value phase |
| bus_wr_i | input | 1 | 1 = write, 0 = read |
| bus_data_i | input | 8 | Data lines from the host |
| bus_data_o | output | 8 | Read byte to the host |
| bus_data_oe_o | output | 1 | Output enable for bus_data_o |
| bus_busy_o | output | 1 | 1 = not complete, retry; 0 = complete |

## Verification
A wrong phase state shows up at the ports within one strobe. A read then returns the low byte where the high byte was expected, or a write lands with its bytes swapped or not at all, and a read-back after the next completion makes either error visible. A wrong address or byte counter after a re-poll or a retried read shows up as the wrong register contents on the first byte of that retry. A busy timer that is loaded at the wrong moment shows up as the busy line already low, or still high, at the host's first status sample after chip-select rises.

// File: rtl/bbt_pkg.sv
package bbt_pkg;
    typedef enum logic [1:0] {
        ST_NOADDR  = 2'd0,
        ST_WAIT_HI = 2'd1,
        ST_WAIT_LO = 2'd2,
        ST_DONE    = 2'd3
    } phase_e;
endpackage

// File: rtl/bbt_sync.sv
module bbt_sync #(
    parameter int             W   = 1,
    parameter logic [W-1:0]   RST = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta;

    for (genvar i = 0; i < W; i++) begin : g_bit
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                meta[i] <= RST[i];
                q[i]    <= RST[i];
            end else begin
                meta[i] <= d[i];
                q[i]    <= meta[i];
            end
        end
    end
endmodule

// File: rtl/bbt_regs.sv
module bbt_regs #(
    parameter int AW = 8,
    parameter int WW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [WW-1:0] wdata,
    output logic [WW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [WW-1:0] mem [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (we) begin
            mem[addr] <= wdata;
        end
    end

    assign rdata = mem[addr];
endmodule

// File: rtl/bbt_ctrl.sv
module bbt_ctrl
    import bbt_pkg::*;
#(
    parameter int DW          = 8,
    parameter int AW          = 8,
    parameter int BUSY_CYCLES = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            stb_s,
    input  logic            sel_n_s,
    input  logic            ale_s,
    input  logic            wr_s,
    input  logic [DW-1:0]   data_s,
    input  logic [2*DW-1:0] rd_word,
    output logic            reg_we,
    output logic [AW-1:0]   reg_addr,
    output logic [2*DW-1:0] reg_wdata,
    output logic [DW-1:0]   data_o,
    output logic            data_oe,
    output logic            busy
);
    localparam int BW = $clog2(BUSY_CYCLES + 2);

    phase_e        state, nxt;
    logic          stb_q, sel_q;
    logic          stb_rise, sel_rise, addr_ev, val_ev, commit;
    logic [AW-1:0] addr_q;
    logic [DW-1:0] hi_q, lo_q;
    logic          wr_q, have_addr;
    logic [BW-1:0] timer;

    assign stb_rise = stb_s & ~stb_q;
    assign sel_rise = sel_n_s & ~sel_q;
    assign addr_ev  = stb_rise & ale_s;
    assign val_ev   = stb_rise & ~ale_s & ~sel_rise;
    assign commit   = sel_rise & ~addr_ev & (state == ST_DONE);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_NOADDR;
        else        state <= nxt;
    end

    // next-state logic
    always_comb begin
        nxt = state;
        if (addr_ev) begin
            nxt = ST_WAIT_HI;
        end else if (sel_rise) begin
            if (state == ST_WAIT_LO || state == ST_DONE) nxt = ST_WAIT_HI;
        end else if (val_ev) begin
            unique case (state)
                ST_WAIT_HI: nxt = ST_WAIT_LO;
                ST_WAIT_LO: nxt = ST_DONE;
                ST_DONE:    nxt = ST_DONE;
                ST_NOADDR:  nxt = ST_NOADDR;
            endcase
        end
    end

    // datapath and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stb_q     <= 1'b0;
            sel_q     <= 1'b1;
            addr_q    <= '0;
            hi_q      <= '0;
            lo_q      <= '0;
            wr_q      <= 1'b0;
            have_addr <= 1'b0;
            data_o    <= '0;
            timer     <= '0;
        end else begin
            stb_q <= stb_s;
            sel_q <= sel_n_s;
            if (addr_ev) begin
                addr_q    <= data_s;
                have_addr <= 1'b1;
            end
            if (val_ev) begin
                unique case (state)
                    ST_WAIT_HI: begin
                        wr_q <= wr_s;
                        if (wr_s) hi_q   <= data_s;
                        else      data_o <= rd_word[2*DW-1:DW];
                    end
                    ST_WAIT_LO: begin
                        wr_q <= wr_q & wr_s;
                        if (wr_s) lo_q   <= data_s;
                        else      data_o <= rd_word[DW-1:0];
                    end
                    ST_DONE, ST_NOADDR: ;
                endcase
            end
            if (commit)          timer <= BW'(BUSY_CYCLES);
            else if (timer != 0) timer <= timer - 1'b1;
        end
    end

    assign reg_we    = commit & wr_q;
    assign reg_addr  = addr_q;
    assign reg_wdata = {hi_q, lo_q};
    assign busy      = (timer != 0);
    assign data_oe   = ~sel_n_s & ~wr_s & ~ale_s & have_addr;

    // checks
    p_addr_latch_r2: assert property (@(posedge clk) disable iff (!rst_n)
        addr_ev |=> (addr_q == $past(data_s)) && (state == ST_WAIT_HI));

    p_busy_start_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(sel_rise));

    p_extra_ignored_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (val_ev && state == ST_DONE) |=> $stable(hi_q) && $stable(lo_q));

    p_oe_needs_addr_r9: assert property (@(posedge clk) disable iff (!rst_n)
        data_oe |-> (state != ST_NOADDR));

    logic [BW:0] chk_run;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      chk_run <= '0;
        else if (commit) chk_run <= (BW+1)'(1);
        else if (busy)   chk_run <= chk_run + 1'b1;
    end

    p_busy_len_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (chk_run == (BW+1)'(BUSY_CYCLES + 1)));
endmodule

// File: rtl/byte_bus_target.sv
module byte_bus_target #(
    parameter int DW          = 8,
    parameter int AW          = 8,
    parameter int BUSY_CYCLES = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bus_strobe_i,
    input  logic          bus_sel_n_i,
    input  logic          bus_ale_i,
    input  logic          bus_wr_i,
    input  logic [DW-1:0] bus_data_i,
    output logic [DW-1:0] bus_data_o,
    output logic          bus_data_oe_o,
    output logic          bus_busy_o
);
    localparam int WW = 2 * DW;

    logic [3:0]    ctl_s;
    logic [DW-1:0] data_s;
    logic          reg_we;
    logic [AW-1:0] reg_addr;
    logic [WW-1:0] reg_wdata, rd_word;

    bbt_sync #(.W(4), .RST(4'b0100)) u_ctl_sync (
        .clk(clk), .rst_n(rst_n),
        .d({bus_strobe_i, bus_sel_n_i, bus_ale_i, bus_wr_i}),
        .q(ctl_s)
    );

    bbt_sync #(.W(DW), .RST('0)) u_dat_sync (
        .clk(clk), .rst_n(rst_n), .d(bus_data_i), .q(data_s)
    );

    bbt_ctrl #(.DW(DW), .AW(AW), .BUSY_CYCLES(BUSY_CYCLES)) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .stb_s(ctl_s[3]), .sel_n_s(ctl_s[2]), .ale_s(ctl_s[1]), .wr_s(ctl_s[0]),
        .data_s(data_s), .rd_word(rd_word),
        .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .data_o(bus_data_o), .data_oe(bus_data_oe_o), .busy(bus_busy_o)
    );

    bbt_regs #(.AW(AW), .WW(WW)) u_regs (
        .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr),
        .wdata(reg_wdata), .rdata(rd_word)
    );
endmodule

// File: tb/byte_bus_target_test.sv
module byte_bus_target_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       stb = 1'b0, sel_n = 1'b1, ale = 1'b0, wr = 1'b0;
    logic [7:0] din = 8'h00;
    logic [7:0] dout;
    logic       oe, busy;
    int         nchk = 0, nfail = 0;

    always #4 clk = ~clk;

    byte_bus_target uut (
        .clk(clk), .rst_n(rst_n), .bus_strobe_i(stb), .bus_sel_n_i(sel_n),
        .bus_ale_i(ale), .bus_wr_i(wr), .bus_data_i(din),
        .bus_data_o(dout), .bus_data_oe_o(oe), .bus_busy_o(busy)
    );

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic phase(input logic a, input logic [7:0] d);
        sel_n = 1'b0; stb = 1'b0; ale = 1'b0; din = 8'h00;
        step(2);
        ale = a; din = d;
        step(3);
        stb = 1'b1;
        step(6);
    endtask

    task automatic finish_txn(output logic b);
        stb = 1'b0;
        step(2);
        sel_n = 1'b1;
        step(6);
        b = busy;
    endtask

    task automatic repoll(output logic b);
        sel_n = 1'b0;
        step(3);
        sel_n = 1'b1;
        step(6);
        b = busy;
    endtask

    task automatic wait_ready();
        logic b;
        b = busy;
        for (int k = 0; k < 10 && b; k++) repoll(b);
    endtask

    task automatic do_write(input logic [7:0] a, input logic [15:0] v);
        logic b;
        wr = 1'b1;
        phase(1'b1, a);
        phase(1'b0, v[15:8]);
        phase(1'b0, v[7:0]);
        finish_txn(b);
        wait_ready();
    endtask

    task automatic do_read(input logic [7:0] a, output logic [15:0] v);
        logic b;
        wr = 1'b0;
        phase(1'b1, a);
        phase(1'b0, 8'h00);
        v[15:8] = dout;
        phase(1'b0, 8'h00);
        v[7:0] = dout;
        finish_txn(b);
        wait_ready();
    endtask

    task automatic t_reset();
        logic [15:0] v;
        chk("R1 busy after reset", {15'd0, busy}, 16'd0);
        chk("R1 oe after reset", {15'd0, oe}, 16'd0);
        chk("R1 data after reset", {8'd0, dout}, 16'd0);
        do_read(8'h05, v);
        chk("R1 register after reset", v, 16'h0000);
    endtask

    task automatic t_write_read();
        logic [15:0] v;
        logic b;
        wr = 1'b1;
        phase(1'b1, 8'h12);
        phase(1'b0, 8'hA5);
        chk("R9 oe low on write", {15'd0, oe}, 16'd0);
        phase(1'b0, 8'h5A);
        finish_txn(b);
        chk("R6 busy after complete write", {15'd0, b}, 16'd1);
        step(30);
        repoll(b);
        chk("R6 busy cleared", {15'd0, b}, 16'd0);
        repoll(b);
        chk("R7 repoll keeps ready", {15'd0, b}, 16'd0);
        wr = 1'b0;
        phase(1'b1, 8'h12);
        phase(1'b0, 8'h00);
        chk("R4 high byte", {8'd0, dout}, 16'h00A5);
        chk("R9 oe high on read", {15'd0, oe}, 16'd1);
        phase(1'b0, 8'h00);
        chk("R4 low byte", {8'd0, dout}, 16'h005A);
        finish_txn(b);
        chk("R9 oe low when deselected", {15'd0, oe}, 16'd0);
        wait_ready();
        do_read(8'h12, v);
        chk("R3 word msb first", v, 16'hA55A);
    endtask

    task automatic t_partial();
        logic [15:0] v;
        logic b;
        wr = 1'b1;
        phase(1'b1, 8'h12);
        phase(1'b0, 8'h77);
        finish_txn(b);
        chk("R5 no busy on partial", {15'd0, b}, 16'd0);
        do_read(8'h12, v);
        chk("R5 register unchanged", v, 16'hA55A);
    endtask

    task automatic t_addr_restart();
        logic [15:0] v;
        logic b;
        wr = 1'b1;
        phase(1'b1, 8'h30);
        phase(1'b0, 8'h11);
        phase(1'b1, 8'h31);
        phase(1'b0, 8'hBE);
        phase(1'b0, 8'hEF);
        finish_txn(b);
        wait_ready();
        do_read(8'h31, v);
        chk("R2 new address restarts count", v, 16'hBEEF);
        do_read(8'h30, v);
        chk("R2 old address untouched", v, 16'h0000);
    endtask

    task automatic t_extra();
        logic [15:0] v;
        logic b;
        wr = 1'b1;
        phase(1'b1, 8'h40);
        phase(1'b0, 8'h12);
        phase(1'b0, 8'h34);
        phase(1'b0, 8'h56);
        finish_txn(b);
        wait_ready();
        do_read(8'h40, v);
        chk("R10 third byte ignored", v, 16'h1234);
    endtask

    task automatic t_retry();
        logic [15:0] v;
        logic b;
        do_read(8'h31, v);
        chk("R8 first read", v, 16'hBEEF);
        wr = 1'b0;
        phase(1'b0, 8'h00);
        chk("R8 retry high byte", {8'd0, dout}, 16'h00BE);
        phase(1'b0, 8'h00);
        chk("R8 retry low byte", {8'd0, dout}, 16'h00EF);
        finish_txn(b);
        wait_ready();
        do_read(8'h12, v);
        chk("R7 repolls changed nothing", v, 16'hA55A);
    endtask

    initial begin
        step(3);
        rst_n = 1'b1;
        step(3);
        t_reset();
        t_write_read();
        t_partial();
        t_addr_restart();
        t_extra();
        t_retry();
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        nchk++;
        nfail++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end
endmodule